// File: doc/BRIEF.md
# Hashed Page Table Group Matcher

This block looks through one group of eight page table entries for the translation of a requested virtual page. Each entry is two 64-bit words: a tag word that holds the abbreviated virtual page, the segment size and a set of flag bits, and a real-page word. The block builds the expected tag from a virtual page number, a segment-size code, a page-size mask and a large-page flag. It then compares that tag against every entry of the group. The result is a hit flag, the index of the winning entry and that entry's real-page word.

The group reaches the block in one of two ways. In the parallel mode, all eight entries sit on a wide bus and are sampled with the start pulse. In the streamed mode, the entries arrive one per accepted beat over eight beats, in index order. A select input states whether the search is for the primary hash or the secondary hash. An entry counts only if its own secondary flag agrees with that select.

Top module: `hpt_group_match`

## Requirements
- R1: The reported tag is ((vpn >> 11) AND NOT pgmask) << 7, ORed with the 2-bit segment code at bits 63:62 and with the large-page input at bit 2. Bits 6:3 and 1:0 of the reported tag are zero.
- R2: An entry's tag word matches when bits 63:7 equal the expected tag. Bits 6:0 take no part in this comparison.
- R3: An entry can hit only if its bit 0 (valid) is 1.
- R4: An entry can hit only if its bit 1 (secondary-hash flag) equals the select input `sec_i` (0 = primary, 1 = secondary).
- R5: When several entries qualify, the lowest index wins. The index is 0..7 and is the entry's position on the group bus, or its beat order in the streamed mode.
- R6: A segment code of 2 or 3 is reserved. Such a search reports `err_o`=1 and `hit_o`=0. Codes 0 (256 MB) and 1 (1 TB) report `err_o`=0.
- R7: In the parallel mode (`stream_i`=0 at start), the results and a one-cycle `done_o` appear in the cycle after the start pulse. Group entry k is tag word `group_i[128k+63:128k]` and real word `group_i[128k+127:128k+64]`.
- R8: In the streamed mode (`stream_i`=1 at start), `busy_o` rises the next cycle. Each cycle with `beat_valid_i`=1 consumes one entry, and cycles without it stall. The results and `done_o` appear in the cycle after the eighth accepted beat, and `busy_o` falls at the same time.
- R9: A start pulse while `busy_o`=1 is ignored. The running search finishes with its own inputs.
- R10: After reset, `busy_o`, `done_o`, `hit_o`, `err_o`, `idx_o`, `rdata_o` and `tag_o` are all zero.
- R11: When `hit_o`=0, `idx_o` and `rdata_o` are zero. All results hold until the next search completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a search (ignored while busy) |
| stream_i | input | 1 | 1 = entries streamed by beats, 0 = whole group on `group_i` |
| sec_i | input | 1 | Hash select: 0 primary, 1 secondary |
| seg_i | input | 2 | Segment size code |
| large_i | input | 1 | Actual page size is not 4 KB |
| vpn_i | input | 64 | Virtual page number (address shifted right by 12) |
| pgmask_i | input | 64 | Page-size bits cleared from the shifted page number |
| group_i | input | 1024 | Eight entries, parallel mode |
| beat_valid_i | input | 1 | Streamed entry present |
| beat_v_i | input | 64 | Streamed tag word |
| beat_r_i | input | 64 | Streamed real-page word |
| busy_o | output | 1 | Streamed search in progress |
| done_o | output | 1 | One-cycle pulse: results updated |
| hit_o | output | 1 | A qualifying entry was found |
| idx_o | output | 3 | Index of winning entry |
| rdata_o | output | 64 | Real-page word of winning entry |
| err_o | output | 1 | Reserved segment code used |
| tag_o | output | 64 | Expected tag built for the search |

## Verification
The assertions check several properties on every cycle. An error never comes with a hit. A miss always leaves the index and the real-page word at zero. A parallel start is followed by `done_o`, and a streamed start by `busy_o` without `done_o`. A stalled stream beat never ends the search, and `busy_o` falls only together with `done_o`. The encoder always names the lowest set qualifying lane, and the built tag keeps its flag positions clear. Only the bench's scenarios can show the arithmetic of the tag, which low bits the comparison ignores, the valid and secondary gating, the winner among several matches, and that a start pulse during a stream leaves that stream's result intact.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  localparam int TAG_FLAG_BITS = 7;   // low flag field excluded from compare
  localparam int VPN_TAG_SHIFT = 11;  // page number bits dropped before tag
  localparam int BIT_VALID     = 0;
  localparam int BIT_SECOND    = 1;
  localparam int BIT_LARGE     = 2;

  typedef enum logic [1:0] {
    SEG_256M = 2'd0,
    SEG_1T   = 2'd1,
    SEG_RSV2 = 2'd2,
    SEG_RSV3 = 2'd3
  } seg_code_e;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_STREAM = 1'b1
  } match_state_e;
endpackage

// File: rtl/hpt_tag_build.sv
module hpt_tag_build
  import hpt_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic [DW-1:0] vpn_i,
  input  logic [DW-1:0] pgmask_i,
  input  logic [1:0]    seg_i,
  input  logic          large_i,
  output logic [DW-1:0] tag_o,
  output logic          rsv_o
);
  logic [DW-1:0] abbrev;

  always_comb begin
    abbrev = (vpn_i >> VPN_TAG_SHIFT) & ~pgmask_i;
    tag_o  = abbrev << TAG_FLAG_BITS;
    tag_o[DW-1:DW-2] = tag_o[DW-1:DW-2] | seg_i;
    tag_o[BIT_LARGE] = large_i;
    rsv_o  = (seg_code_e'(seg_i) == SEG_RSV2) || (seg_code_e'(seg_i) == SEG_RSV3);
  end

  // R1: the only flag bit the builder may set is the large flag
  always_comb begin
    p_tag_flags_r1: assert (tag_o[TAG_FLAG_BITS-1:BIT_LARGE+1] == '0 &&
                            tag_o[BIT_SECOND:BIT_VALID] == '0);
  end
endmodule

// File: rtl/hpt_lane_cmp.sv
module hpt_lane_cmp
  import hpt_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic [DW-1:0] v_i,
  input  logic [DW-1:0] tag_i,
  input  logic          sec_i,
  output logic          hit_o
);
  localparam logic [DW-1:0] CMP_MASK = ~((DW'(1) << TAG_FLAG_BITS) - DW'(1));

  logic tag_eq;
  always_comb begin
    tag_eq = ((v_i ^ tag_i) & CMP_MASK) == '0;               // R2
    hit_o  = tag_eq && v_i[BIT_VALID] && (v_i[BIT_SECOND] == sec_i); // R3 R4
  end
endmodule

// File: rtl/hpt_prio.sv
module hpt_prio #(
  parameter int N_ENT = 8,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic [N_ENT-1:0] vec_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = |vec_i;
    idx_o = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end

  // R5: chosen lane is set and nothing below it is
  always_comb begin
    if (any_o) begin
      p_lowest_r5: assert (vec_i[idx_o] &&
        ((vec_i & ((N_ENT'(1) << idx_o) - N_ENT'(1))) == '0));
    end
  end
endmodule

// File: rtl/hpt_group_match.sv
module hpt_group_match
  import hpt_pkg::*;
#(
  parameter int N_ENT = 8,
  parameter int DW    = 64
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start_i,
  input  logic                        stream_i,
  input  logic                        sec_i,
  input  logic [1:0]                  seg_i,
  input  logic                        large_i,
  input  logic [DW-1:0]               vpn_i,
  input  logic [DW-1:0]               pgmask_i,
  input  logic [N_ENT*2*DW-1:0]       group_i,
  input  logic                        beat_valid_i,
  input  logic [DW-1:0]               beat_v_i,
  input  logic [DW-1:0]               beat_r_i,
  output logic                        busy_o,
  output logic                        done_o,
  output logic                        hit_o,
  output logic [$clog2(N_ENT)-1:0]    idx_o,
  output logic [DW-1:0]               rdata_o,
  output logic                        err_o,
  output logic [DW-1:0]               tag_o
);
  localparam int IDX_W = $clog2(N_ENT);
  localparam int ENT_W = 2 * DW;

  // ---------------- tag construction ----------------
  logic [DW-1:0] tag_now;
  logic          rsv_now;

  hpt_tag_build #(.DW(DW)) u_tag (
    .vpn_i   (vpn_i),
    .pgmask_i(pgmask_i),
    .seg_i   (seg_i),
    .large_i (large_i),
    .tag_o   (tag_now),
    .rsv_o   (rsv_now)
  );

  // ---------------- parallel lanes ----------------
  logic [N_ENT-1:0] par_vec;
  logic             par_any;
  logic [IDX_W-1:0] par_idx;
  logic [DW-1:0]    par_rd;

  for (genvar k = 0; k < N_ENT; k++) begin : g_lane
    hpt_lane_cmp #(.DW(DW)) u_cmp (
      .v_i  (group_i[k*ENT_W +: DW]),
      .tag_i(tag_now),
      .sec_i(sec_i),
      .hit_o(par_vec[k])
    );
  end

  hpt_prio #(.N_ENT(N_ENT)) u_prio (
    .vec_i(par_vec),
    .any_o(par_any),
    .idx_o(par_idx)
  );

  always_comb par_rd = group_i[int'(par_idx)*ENT_W + DW +: DW];

  // ---------------- streamed path ----------------
  match_state_e     state_q;
  logic [DW-1:0]    tag_q;
  logic             sec_q;
  logic             rsv_q;
  logic [IDX_W-1:0] cnt_q;
  logic             found_q;
  logic [IDX_W-1:0] fidx_q;
  logic [DW-1:0]    frd_q;
  logic             beat_hit;

  hpt_lane_cmp #(.DW(DW)) u_beat_cmp (
    .v_i  (beat_v_i),
    .tag_i(tag_q),
    .sec_i(sec_q),
    .hit_o(beat_hit)
  );

  logic             last_beat;
  logic             fin_hit;
  logic [IDX_W-1:0] fin_idx;
  logic [DW-1:0]    fin_rd;

  always_comb begin
    last_beat = beat_valid_i && (cnt_q == IDX_W'(N_ENT - 1));
    fin_hit   = (found_q || beat_hit) && !rsv_q;
    fin_idx   = '0;
    fin_rd    = '0;
    if (fin_hit) begin
      fin_idx = found_q ? fidx_q : cnt_q;
      fin_rd  = found_q ? frd_q  : beat_r_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      tag_q   <= '0;
      sec_q   <= 1'b0;
      rsv_q   <= 1'b0;
      cnt_q   <= '0;
      found_q <= 1'b0;
      fidx_q  <= '0;
      frd_q   <= '0;
      done_o  <= 1'b0;
      hit_o   <= 1'b0;
      idx_o   <= '0;
      rdata_o <= '0;
      err_o   <= 1'b0;
      tag_o   <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (!stream_i) begin
              done_o  <= 1'b1;
              tag_o   <= tag_now;
              err_o   <= rsv_now;
              hit_o   <= par_any && !rsv_now;
              idx_o   <= (par_any && !rsv_now) ? par_idx : '0;
              rdata_o <= (par_any && !rsv_now) ? par_rd  : '0;
            end else begin
              state_q <= ST_STREAM;
              tag_q   <= tag_now;
              sec_q   <= sec_i;
              rsv_q   <= rsv_now;
              cnt_q   <= '0;
              found_q <= 1'b0;
              fidx_q  <= '0;
              frd_q   <= '0;
            end
          end
        end
        ST_STREAM: begin
          if (beat_valid_i) begin
            cnt_q <= cnt_q + IDX_W'(1);
            if (!found_q && beat_hit) begin
              found_q <= 1'b1;
              fidx_q  <= cnt_q;
              frd_q   <= beat_r_i;
            end
            if (last_beat) begin
              state_q <= ST_IDLE;
              done_o  <= 1'b1;
              tag_o   <= tag_q;
              err_o   <= rsv_q;
              hit_o   <= fin_hit;
              idx_o   <= fin_idx;
              rdata_o <= fin_rd;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q == ST_STREAM);

  // ---------------- assertions ----------------
  p_err_nohit_r6: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !hit_o);

  p_miss_clean_r11: assert property (@(posedge clk) disable iff (rst)
    !hit_o |-> (idx_o == '0 && rdata_o == '0));

  p_par_done_r7: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && !stream_i) |=> done_o);

  p_stream_go_r8: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && stream_i) |=> (busy_o && !done_o));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !beat_valid_i) |=> (busy_o && !done_o));

  p_end_done_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);

  p_busy_start_r9: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && !beat_valid_i) |=> !done_o);
endmodule

// File: tb/tb_hpt_group_match.sv
module tb_hpt_group_match;
  localparam int N = 8;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic              start_i = 0, stream_i = 0, sec_i = 0, large_i = 0;
  logic [1:0]        seg_i = 0;
  logic [DW-1:0]     vpn_i = '0, pgmask_i = '0;
  logic [N*2*DW-1:0] group_i = '0;
  logic              beat_valid_i = 0;
  logic [DW-1:0]     beat_v_i = '0, beat_r_i = '0;
  logic              busy_o, done_o, hit_o, err_o;
  logic [2:0]        idx_o;
  logic [DW-1:0]     rdata_o, tag_o;

  hpt_group_match #(.N_ENT(N), .DW(DW)) dut (.*);

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] ev [N];
  logic [DW-1:0] er [N];

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ref_tag();
    logic [DW-1:0] t;
    t = ((vpn_i >> 11) & ~pgmask_i) << 7;
    t[63:62] = t[63:62] | seg_i;
    t[2] = large_i;
    return t;
  endfunction

  task automatic ref_search(output logic h, output logic [2:0] ix,
                            output logic [DW-1:0] rd, output logic e);
    logic [DW-1:0] t;
    t = ref_tag();
    e = seg_i[1];
    h = 1'b0; ix = '0; rd = '0;
    if (!e) begin
      for (int k = N - 1; k >= 0; k--) begin
        if (ev[k][63:7] == t[63:7] && ev[k][0] && ev[k][1] == sec_i) begin
          h = 1'b1; ix = 3'(k); rd = er[k];
        end
      end
    end
  endtask

  task automatic check_result(string req);
    logic h, e; logic [2:0] ix; logic [DW-1:0] rd;
    ref_search(h, ix, rd, e);
    chk({req, " done"}, 64'(done_o), 64'd1);
    chk({req, " hit"}, 64'(hit_o), 64'(h));
    chk({req, " idx"}, 64'(idx_o), 64'(ix));
    chk({req, " rdata"}, rdata_o, rd);
    chk({req, " err"}, 64'(err_o), 64'(e));
    chk({req, " R1 tag"}, tag_o, ref_tag());
  endtask

  task automatic do_par(string req);
    @(negedge clk);
    for (int k = 0; k < N; k++) begin
      group_i[k*128 +: 64]    = ev[k];
      group_i[k*128+64 +: 64] = er[k];
    end
    stream_i = 0; start_i = 1;
    @(negedge clk);
    start_i = 0;
    check_result({req, " R7"});
  endtask

  task automatic do_stream(string req, int stall_pct, bit poke);
    logic [DW-1:0] sv_vpn;
    @(negedge clk);
    stream_i = 1; start_i = 1;
    @(negedge clk);
    start_i = 0;
    chk({req, " R8 busy up"}, 64'(busy_o), 64'd1);
    sv_vpn = vpn_i;
    for (int k = 0; k < N; k++) begin
      while (($urandom % 100) < stall_pct) begin
        beat_valid_i = 0;
        if (poke) begin
          start_i = 1; stream_i = 0; vpn_i = ~sv_vpn;   // R9: ignored
        end
        @(negedge clk);
        start_i = 0; vpn_i = sv_vpn;
        chk({req, " R9 no early done"}, 64'(done_o), 64'd0);
      end
      beat_valid_i = 1; beat_v_i = ev[k]; beat_r_i = er[k];
      @(negedge clk);
      beat_valid_i = 0;
      if (k == 3) chk({req, " R8 mid busy"}, 64'(busy_o), 64'd1);
    end
    chk({req, " R8 busy down"}, 64'(busy_o), 64'd0);
    check_result({req, " R8"});
  endtask

  task automatic fill_random();
    logic [DW-1:0] t;
    t = ref_tag();
    for (int k = 0; k < N; k++) begin
      ev[k] = {$urandom, $urandom};
      er[k] = {$urandom, $urandom};
      if (($urandom % 3) != 0)
        ev[k] = {t[63:7], 7'($urandom)};
    end
  endtask

  task automatic rand_inputs();
    vpn_i    = {$urandom, $urandom};
    pgmask_i = (64'd1 << ($urandom % 13)) - 64'd1;
    seg_i    = (($urandom % 8) == 0) ? 2'(2 + $urandom % 2) : 2'($urandom % 2);
    large_i  = 1'($urandom);
    sec_i    = 1'($urandom);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] t;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk("R10 busy", 64'(busy_o), 0);
    chk("R10 done", 64'(done_o), 0);
    chk("R10 hit", 64'(hit_o), 0);
    chk("R10 err", 64'(err_o), 0);
    chk("R10 idx", 64'(idx_o), 0);
    chk("R10 rdata", rdata_o, 0);
    chk("R10 tag", tag_o, 0);

    // directed: R5 two qualifying entries, lowest wins
    vpn_i = 64'h0123_4567_89AB_CDEF; pgmask_i = 64'hFF; seg_i = 2'd1;
    large_i = 1; sec_i = 0;
    t = ref_tag();
    for (int k = 0; k < N; k++) begin ev[k] = ~t; er[k] = 64'(k) * 64'h1111; end
    ev[5] = {t[63:7], 7'b0000001}; ev[2] = {t[63:7], 7'b1111101};
    do_par("R5 lowest");
    do_stream("R5 lowest", 30, 0);

    // R2: low flag bits differ but match; bit 7 differs misses
    ev[2] = {t[63:7] ^ 57'h1, 7'b0000001};
    ev[5] = {t[63:7], 7'b1111101};
    do_par("R2 low bits");
    // R3: matching tag but invalid only
    ev[5] = {t[63:7], 7'b0000000};
    do_par("R3 invalid");
    do_stream("R3 invalid", 0, 0);
    // R4: wrong secondary flag only, then right one
    ev[5] = {t[63:7], 7'b0000011};
    do_par("R4 sec mismatch");
    sec_i = 1;
    do_par("R4 sec match");
    // R6: reserved segment codes
    seg_i = 2'd2; t = ref_tag();
    ev[1] = {t[63:7], 7'b0000011};
    do_par("R6 seg2");
    seg_i = 2'd3; t = ref_tag();
    ev[1] = {t[63:7], 7'b0000011};
    do_stream("R6 seg3", 20, 0);
    // R9 + R11: start pokes during a stream; then a miss clears outputs
    seg_i = 2'd0; t = ref_tag();
    for (int k = 0; k < N; k++) ev[k] = {t[63:7], 7'b0000011};
    do_stream("R9 poke", 50, 1);
    for (int k = 0; k < N; k++) ev[k] = ~t;
    do_par("R11 miss clear");

    // constrained random
    for (int it = 0; it < 300; it++) begin
      rand_inputs();
      fill_random();
      if (it % 2 == 0) do_par("R2/R3/R4/R5 rand");
      else do_stream("R2/R3/R4/R5 rand", 25, (it % 5) == 1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule